// File: doc/BRIEF.md
# Fixed Off-Time Chopper Current Controller

This block decides, cycle by cycle, whether the high-side source driver of a motor bridge may conduct and, while it may not, whether the winding current recirculates in fast or slow decay. Timing is counted in ticks of an oscillator-rate clock enable. When a digital trip comparator reports that the winding current has reached its limit, the block turns the source off for a fixed off time set by a 5-bit field. After the off time it turns the source back on behind a blanking window. During that window the trip input is ignored, so that switching spikes cannot end the on time early.

In mixed decay the off time opens with a fast-decay portion set by a 4-bit field and finishes in slow decay. In slow decay the whole off time is slow. Two event inputs, one for an external chop command and one for a direction change, abort whatever the controller is doing and start a fresh blanking window with the source on.

The controller is a five-state machine. IDLE is the reset state: the source is off and no decay is signalled. BLANK means the source is on and the trip input is masked. DRIVE means the source is on and the trip input is watched. OFF_FAST and OFF_SLOW are the two parts of the off time. The transitions are:
- **evt_restart**: any state to BLANK on an event.
- **blank_done**: BLANK to DRIVE.
- **trip_mixed**: DRIVE to OFF_FAST.
- **trip_slow**: DRIVE to OFF_SLOW.
- **fast_done**: OFF_FAST to OFF_SLOW.
- **off_done**: OFF_FAST or OFF_SLOW to BLANK.

Top module: `pwm_offtime_ctrl`

## Requirements
- R1: Synchronous reset puts the controller in IDLE with `src_en` = 0 and `decay` = 2'b00. The controller stays there, whatever `trip` does, until a chop or phase event arrives.
- R2: A one-cycle pulse on `chop_evt` or `phase_evt` in any state is acted on at the next clock edge, whether or not `osc_tick` is high. After that edge `src_en` = 1, `decay` = 2'b00, and a new blanking window begins. This applies even if a window or an off time was in progress.
- R3: The blanking window lasts 4, 6, 12 or 24 ticks for `blank_code` 2'b00, 2'b01, 2'b10 and 2'b11 respectively. `trip` is ignored during the window.
- R4: After blanking, the first tick cycle with `trip` = 1 starts the off time. From the next clock edge `src_en` = 0. Without a trip, `src_en` stays 1.
- R5: The off time lasts 8*(1+N)-1 ticks, where N = `off_code`. At the edge that ends it, `src_en` returns to 1 and a new blanking window starts.
- R6: With `mixed_sel` = 1, the off time shows `decay` = 2'b10 (fast) for 8*(1+M)-1 ticks, where M = `fast_code`, and then 2'b01 (slow) for the rest of the off time. Fast never follows slow within one off time. `decay` is 2'b00 whenever `src_en` = 1.
- R7: With `mixed_sel` = 1 and a fast-decay length equal to or longer than the off time (M >= N), the whole off time shows fast decay.
- R8: With `mixed_sel` = 0 at the moment of the trip, the whole off time shows slow decay.
- R9: The timers advance only in cycles with `osc_tick` = 1. `trip` is sampled only in those cycles. With `osc_tick` low and no event, the state does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| osc_tick | input | 1 | Oscillator-rate clock enable; one tick per high cycle |
| trip | input | 1 | Current-trip comparator output, high at or above the limit |
| blank_code | input | 2 | Blanking window select |
| off_code | input | 5 | Off-time field N |
| fast_code | input | 4 | Fast-decay field M |
| mixed_sel | input | 1 | 1 = mixed decay, 0 = slow decay |
| chop_evt | input | 1 | External chop event, one-cycle pulse |
| phase_evt | input | 1 | Direction change event, one-cycle pulse |
| src_en | output | 1 | Source-driver enable |
| decay | output | 2 | 2'b00 none, 2'b01 slow, 2'b10 fast |

## Verification
The following properties are checked on every cycle:
- every event lands the machine in BLANK;
- a trip seen in BLANK never drops the source;
- the source only falls after a ticked trip in DRIVE;
- fast decay never follows slow decay;
- fast decay needs the mixed select;
- nothing moves without a tick or an event.

The lengths of the blanking window, the off time and the fast part are counts over many cycles. Only the bench can show them, by sweeping every off and fast field pair and every blank code, and by comparing the measured run lengths with 8*(1+N)-1 and the blank table.

// File: rtl/pwm_offtime_pkg.sv
package pwm_offtime_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_BLANK    = 3'd1,
        ST_DRIVE    = 3'd2,
        ST_OFF_FAST = 3'd3,
        ST_OFF_SLOW = 3'd4
    } chop_state_t;

    typedef enum logic [1:0] {
        DECAY_NONE = 2'b00,
        DECAY_SLOW = 2'b01,
        DECAY_FAST = 2'b10
    } decay_t;

endpackage

// File: rtl/pwm_interval_calc.sv
// Converts programmed fields into terminal counts (length - 1).
module pwm_interval_calc #(
    parameter int unsigned OFF_W     = 5,
    parameter int unsigned FAST_W    = 4,
    parameter int unsigned BCODE_W   = 2,
    parameter int unsigned SCALE     = 8,
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned BLANK_TBL [2**BCODE_W] = '{4, 6, 12, 24}
) (
    input  logic [BCODE_W-1:0] blank_code,
    input  logic [OFF_W-1:0]   off_code,
    input  logic [FAST_W-1:0]  fast_code,
    output logic [CNT_W-1:0]   off_last,
    output logic [CNT_W-1:0]   fast_last,
    output logic [CNT_W-1:0]   blank_last
);
    int unsigned off_len;
    int unsigned fast_len;
    int unsigned blank_len;

    always_comb begin
        // length = SCALE*(1+field) - 1, terminal = length - 1
        off_len    = (SCALE * (int'(off_code) + 1)) - 1;
        fast_len   = (SCALE * (int'(fast_code) + 1)) - 1;
        blank_len  = BLANK_TBL[blank_code];
        off_last   = CNT_W'(off_len - 1);
        fast_last  = CNT_W'(fast_len - 1);
        blank_last = CNT_W'(blank_len - 1);
    end
endmodule

// File: rtl/pwm_tick_counter.sv
// Saturating tick counter shared by blank, off and fast intervals.
module pwm_tick_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             tick,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            count <= '0;
        end else if (tick && (count != CNT_MAX)) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_chop_fsm.sv
// Chopper state machine: state register plus next-state logic.
module pwm_chop_fsm
    import pwm_offtime_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        trip,
    input  logic        evt,
    input  logic        mixed,
    input  logic        blank_hit,
    input  logic        off_hit,
    input  logic        fast_hit,
    output chop_state_t state_q,
    output logic        restart
);
    chop_state_t state_n;
    logic        keeps_count;

    always_comb begin
        state_n = state_q;
        if (evt) begin
            state_n = ST_BLANK;                       // evt_restart
        end else if (tick) begin
            unique case (state_q)
                ST_IDLE:     state_n = ST_IDLE;
                ST_BLANK:    if (blank_hit) state_n = ST_DRIVE;   // blank_done
                ST_DRIVE:    if (trip) state_n = mixed ? ST_OFF_FAST : ST_OFF_SLOW;
                ST_OFF_FAST: begin
                    if (off_hit)       state_n = ST_BLANK;        // off_done
                    else if (fast_hit) state_n = ST_OFF_SLOW;     // fast_done
                end
                ST_OFF_SLOW: if (off_hit) state_n = ST_BLANK;     // off_done
                default:     state_n = ST_IDLE;
            endcase
        end
    end

    // The off-time count runs on across the fast-to-slow boundary.
    assign keeps_count = (state_q == ST_OFF_FAST) && (state_n == ST_OFF_SLOW);
    assign restart     = evt || ((state_n != state_q) && !keeps_count);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end
endmodule

// File: rtl/pwm_offtime_ctrl.sv
module pwm_offtime_ctrl
    import pwm_offtime_pkg::*;
#(
    parameter int unsigned OFF_W   = 5,
    parameter int unsigned FAST_W  = 4,
    parameter int unsigned BCODE_W = 2,
    parameter int unsigned SCALE   = 8,
    parameter int unsigned BLANK_TBL [2**BCODE_W] = '{4, 6, 12, 24}
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               osc_tick,
    input  logic               trip,
    input  logic [BCODE_W-1:0] blank_code,
    input  logic [OFF_W-1:0]   off_code,
    input  logic [FAST_W-1:0]  fast_code,
    input  logic               mixed_sel,
    input  logic               chop_evt,
    input  logic               phase_evt,
    output logic               src_en,
    output logic [1:0]         decay
);
    localparam int unsigned OFF_SPAN = SCALE * (2 ** OFF_W);
    localparam int unsigned CNT_W    = $clog2(OFF_SPAN);

    logic [CNT_W-1:0] off_last;
    logic [CNT_W-1:0] fast_last;
    logic [CNT_W-1:0] blank_last;
    logic [CNT_W-1:0] count;
    logic             restart;
    logic             evt;
    chop_state_t      state_q;

    assign evt = chop_evt || phase_evt;

    pwm_interval_calc #(
        .OFF_W     (OFF_W),
        .FAST_W    (FAST_W),
        .BCODE_W   (BCODE_W),
        .SCALE     (SCALE),
        .CNT_W     (CNT_W),
        .BLANK_TBL (BLANK_TBL)
    ) u_calc (
        .blank_code (blank_code),
        .off_code   (off_code),
        .fast_code  (fast_code),
        .off_last   (off_last),
        .fast_last  (fast_last),
        .blank_last (blank_last)
    );

    pwm_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .tick    (osc_tick),
        .count   (count)
    );

    pwm_chop_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .tick      (osc_tick),
        .trip      (trip),
        .evt       (evt),
        .mixed     (mixed_sel),
        .blank_hit (count == blank_last),
        .off_hit   (count == off_last),
        .fast_hit  (count == fast_last),
        .state_q   (state_q),
        .restart   (restart)
    );

    // Moore output decode
    always_comb begin
        src_en = 1'b0;
        decay  = DECAY_NONE;
        unique case (state_q)
            ST_IDLE:     ;
            ST_BLANK:    src_en = 1'b1;
            ST_DRIVE:    src_en = 1'b1;
            ST_OFF_FAST: decay  = DECAY_FAST;
            ST_OFF_SLOW: decay  = DECAY_SLOW;
            default:     ;
        endcase
    end
endmodule

// File: rtl/pwm_offtime_chk.sv
module pwm_offtime_chk
    import pwm_offtime_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        osc_tick,
    input logic        trip,
    input logic        mixed_sel,
    input logic        chop_evt,
    input logic        phase_evt,
    input logic        src_en,
    input logic [1:0]  decay,
    input chop_state_t state
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!src_en && decay == 2'b00));

    p_idle_holds_r1: assert property (@(posedge clk) disable iff (rst)
        ($past(state == ST_IDLE) && !$past(chop_evt || phase_evt)) |-> (state == ST_IDLE));

    p_evt_blank_r2: assert property (@(posedge clk) disable iff (rst)
        (chop_evt || phase_evt) |=> (state == ST_BLANK && src_en && decay == 2'b00));

    p_blank_masks_trip_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BLANK && trip && !chop_evt && !phase_evt) |=> src_en);

    p_fall_needs_trip_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(src_en) |-> $past(trip && osc_tick && state == ST_DRIVE));

    p_rise_cause_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(src_en) |-> ($past(chop_evt || phase_evt) || ($past(osc_tick) && $past(decay) != 2'b00)));

    p_decay_code_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({src_en, decay}));

    p_no_fast_after_slow_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(decay) == 2'b01 && !$past(chop_evt || phase_evt)) |-> decay != 2'b10);

    p_fast_needs_mixed_r8: assert property (@(posedge clk) disable iff (rst)
        (decay == 2'b10 && $past(decay) != 2'b10) |-> $past(mixed_sel));

    p_frozen_no_tick_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(!osc_tick && !chop_evt && !phase_evt && !rst)) |-> $stable(state));
endmodule

bind pwm_offtime_ctrl pwm_offtime_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .osc_tick  (osc_tick),
    .trip      (trip),
    .mixed_sel (mixed_sel),
    .chop_evt  (chop_evt),
    .phase_evt (phase_evt),
    .src_en    (src_en),
    .decay     (decay),
    .state     (state_q)
);

// File: tb/sim_pwm_offtime_ctrl.sv
module sim_pwm_offtime_ctrl;
    localparam int CLK_T = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_tick = 1'b1;
    logic       trip = 1'b0;
    logic [1:0] blank_code = 2'b00;
    logic [4:0] off_code = 5'd0;
    logic [3:0] fast_code = 4'd0;
    logic       mixed_sel = 1'b1;
    logic       chop_evt = 1'b0;
    logic       phase_evt = 1'b0;
    logic       src_en;
    logic [1:0] decay;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_T/2) clk = ~clk;

    pwm_offtime_ctrl u0 (
        .clk        (clk),
        .rst        (rst),
        .osc_tick   (osc_tick),
        .trip       (trip),
        .blank_code (blank_code),
        .off_code   (off_code),
        .fast_code  (fast_code),
        .mixed_sel  (mixed_sel),
        .chop_evt   (chop_evt),
        .phase_evt  (phase_evt),
        .src_en     (src_en),
        .decay      (decay)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int blank_len(input int code);
        return (code == 0) ? 4 : (code == 1) ? 6 : (code == 2) ? 12 : 24;
    endfunction

    // Event, trip held high: source high for B+1 samples, then off time.
    task automatic run_case(input int n, input int m, input int bc, input bit mix, input bit use_phase);
        int hi = 0;
        int fast = 0;
        int slow = 0;
        int bad = 0;
        int order_err = 0;
        int guard = 0;
        int toff = 8 * (n + 1) - 1;
        int tfd = 8 * (m + 1) - 1;
        int exp_fast = mix ? ((tfd < toff) ? tfd : toff) : 0;
        off_code = 5'(n); fast_code = 4'(m); blank_code = 2'(bc); mixed_sel = mix;
        trip = 1'b1;
        if (use_phase) phase_evt = 1'b1; else chop_evt = 1'b1;
        step();
        chop_evt = 1'b0; phase_evt = 1'b0;
        while (src_en && hi < 100) begin
            if (decay != 2'b00) bad++;
            hi++;
            step();
        end
        while (!src_en && guard < 400) begin
            if (decay == 2'b10) begin
                fast++;
                if (slow > 0) order_err++;
            end else if (decay == 2'b01) slow++;
            else bad++;
            guard++;
            step();
        end
        check(hi == blank_len(bc) + 1, "R3 blank window+1", hi, blank_len(bc) + 1);
        check(fast + slow == toff, "R5 off time", fast + slow, toff);
        if (!mix) check(fast == 0 && slow == toff, "R8 slow only", fast, 0);
        else if (m >= n) check(fast == toff, "R7 whole fast", fast, toff);
        else check(fast == exp_fast, "R6 fast part", fast, exp_fast);
        check(order_err == 0 && bad == 0, "R6 decay order/code", order_err + bad, 0);
        check(src_en == 1'b1, "R5 source back on", src_en, 1);
        trip = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int cnt;
        int bad;
        logic [1:0] held;
        // R1: reset state and idle hold
        trip = 1'b1;
        repeat (4) step();
        rst = 1'b0;
        step();
        check(src_en == 1'b0 && decay == 2'b00, "R1 reset state", {src_en, decay}, 0);
        bad = 0;
        for (int i = 0; i < 12; i++) begin
            step();
            if (src_en || decay != 2'b00) bad++;
        end
        check(bad == 0, "R1 idle ignores trip", bad, 0);

        // R4: no trip keeps source on; trip drops it one edge later
        trip = 1'b0; blank_code = 2'b00; mixed_sel = 1'b1; off_code = 5'd2; fast_code = 4'd0;
        chop_evt = 1'b1; step(); chop_evt = 1'b0;
        repeat (40) step();
        check(src_en == 1'b1, "R4 stays on without trip", src_en, 1);
        trip = 1'b1; step();
        check(src_en == 1'b0 && decay == 2'b10, "R4 trip ends drive", {src_en, decay}, 2);
        trip = 1'b0;

        // R2: event during off time restarts blanking
        repeat (5) step();
        check(src_en == 1'b0, "R2 still off before event", src_en, 0);
        phase_evt = 1'b1; step(); phase_evt = 1'b0;
        check(src_en == 1'b1 && decay == 2'b00, "R2 event aborts off time", {src_en, decay}, 4);

        // R2: event during blanking restarts the window
        blank_code = 2'b11; trip = 1'b1;
        chop_evt = 1'b1; step(); chop_evt = 1'b0;
        repeat (10) step();
        phase_evt = 1'b1; step(); phase_evt = 1'b0;
        cnt = 0;
        while (src_en && cnt < 100) begin cnt++; step(); end
        check(cnt == 25, "R2 window restarted", cnt, 25);

        // R9: no ticks freeze blanking and off time
        osc_tick = 1'b0; blank_code = 2'b01; trip = 1'b1;
        chop_evt = 1'b1; step(); chop_evt = 1'b0;
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            if (!src_en) bad++;
            step();
        end
        check(bad == 0, "R9 blank frozen", bad, 0);
        osc_tick = 1'b1;
        cnt = 0;
        step();
        while (src_en && cnt < 100) begin cnt++; step(); end
        check(cnt == 6, "R9 blank resumes in ticks", cnt, 6);
        osc_tick = 1'b0;
        held = decay;
        bad = 0;
        for (int i = 0; i < 30; i++) begin
            step();
            if (src_en || decay != held) bad++;
        end
        check(bad == 0, "R9 off time frozen", bad, 0);
        osc_tick = 1'b1; trip = 1'b0;

        // R3, R5, R6, R7: mixed sweep over all off and fast fields
        for (int n = 0; n < 32; n++)
            for (int m = 0; m < 16; m++)
                run_case(n, m, (n + m) % 4, 1'b1, (m % 2) == 1);
        // R8: slow sweep
        for (int n = 0; n < 32; n++)
            run_case(n, n % 16, n % 4, 1'b0, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule